// File: doc/BRIEF.md
# Line-Timed Clamp Pulse Generator

This block runs on the pixel clock. It turns an incoming horizontal sync into a clamp strobe for each line. It also regenerates a horizontal sync output pulse.

The raw sync first passes through a polarity select, a two-stage synchronizer and an edge detector. Each trailing edge of the active sync level starts a two-step sequence. The first step is a wait whose length is the placement setting. The second step is a clamp pulse whose length is the duration setting. A mode input can replace this internal strobe with an external clamp input, which is passed straight through.

A separate line-reference strobe starts the sync output pulse, and the pulse lasts for the width setting. All three settings are captured at each detected trailing edge, so a change made in mid-line applies from the next line.

Top module: `clamp_strobe_gen`

## Requirements
- R1: When `clamp_src_ext` is 1, `clamp_out` equals `clamp_ext` in the same cycle, and the placement and duration settings have no effect on it.
- R2: With `hs_pol` = 1 the active sync level is high; with `hs_pol` = 0 it is low. A trailing edge is the change from the active level to the inactive level. If edge E0 is the first rising clock edge that samples the inactive level after at least one sample at the active level, the sequence starts at edge E0+2.
- R3: In internal mode (`clamp_src_ext` = 0), `clamp_out` rises after edge S+P, where S is the sequence start edge and P is the placement value captured at S.
- R4: A placement value of 0 behaves exactly like a placement value of 1.
- R5: The internal clamp stays high for D clock cycles, where D is the duration value captured at S. When D = 0, that line has no clamp pulse.
- R6: A trailing edge detected while a wait or a clamp pulse is still running ends that activity at once and restarts the sequence from the new edge.
- R7: When `line_ref` is high at edge F, `hsync_out` is high after edges F through F+W-1, where W is the width captured at the most recent trailing edge before F. A new `line_ref` reloads the count.
- R8: A captured width of 0 produces no `hsync_out` pulse.
- R9: Placement, duration and width are captured only at trailing edges. Before the first trailing edge after reset, the captured width is 0.
- R10: A synchronous active-high `rst` clears the synchronizer, the counters and the captured settings. While reset is held, `hsync_out` is low, and `clamp_out` is low in internal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_raw | input | 1 | Raw horizontal sync |
| hs_pol | input | 1 | 1: sync is active high; 0: sync is active low |
| line_ref | input | 1 | Line-reference strobe that starts the sync output pulse |
| clamp_ext | input | 1 | External clamp, used when `clamp_src_ext` is 1 |
| clamp_src_ext | input | 1 | Clamp source select: 0 internal, 1 external |
| place_cfg | input | 8 | Delay from trailing edge to clamp start, in pixel periods |
| dur_cfg | input | 8 | Clamp length in pixel periods |
| hs_width_cfg | input | 8 | Sync output pulse width in pixel periods |
| clamp_out | output | 1 | Clamp strobe |
| hsync_out | output | 1 | Regenerated sync pulse |

## Verification
Directed lines cover each corner case on its own:
- a width change before the first trailing edge, to check that the setting is captured only at trailing edges;
- a placement of 0, to check that it is treated as 1;
- a duration of 0, to check that no clamp pulse appears;
- lines shorter than placement plus duration, so that the restart on a new edge shows up;
- a width of 0;
- an active-low sync, to check the polarity select;
- external mode with a toggling external clamp.

Constrained-random lines then mix random placement, duration, width, line length, sync width, reference position and clamp source. These runs separate off-by-one errors in the wait count and in the pulse count, because every output is compared each cycle against windows computed from the captured settings.

// File: rtl/clamp_strobe_gen.sv
module clamp_strobe_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hs_raw,
  input  logic         hs_pol,
  input  logic         line_ref,
  input  logic         clamp_ext,
  input  logic         clamp_src_ext,
  input  logic [W-1:0] place_cfg,
  input  logic [W-1:0] dur_cfg,
  input  logic [W-1:0] hs_width_cfg,
  output logic         clamp_out,
  output logic         hsync_out
);

  typedef enum logic [1:0] {IDLE, WAIT, HOLD} phase_t;

  localparam logic [W-1:0] ONE = W'(1);

  logic [2:0]   sync_q;
  logic         trail;
  logic         clamp_int;
  phase_t       phase;
  logic [W-1:0] cnt;
  logic [W-1:0] dur_l;
  logic [W-1:0] wid_l;
  logic [W-1:0] hs_cnt;

  wire act_in = hs_pol ? hs_raw : ~hs_raw;

  assign trail     = sync_q[2] & ~sync_q[1];
  assign clamp_int = (phase == HOLD);
  assign clamp_out = clamp_src_ext ? clamp_ext : clamp_int;
  assign hsync_out = (hs_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[1:0], act_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= IDLE;
      cnt   <= '0;
      dur_l <= '0;
      wid_l <= '0;
    end else if (trail) begin
      phase <= WAIT;
      cnt   <= (place_cfg == '0) ? ONE : place_cfg;
      dur_l <= dur_cfg;
      wid_l <= hs_width_cfg;
    end else begin
      case (phase)
        WAIT: begin
          if (cnt == ONE) begin
            phase <= (dur_l == '0) ? IDLE : HOLD;
            cnt   <= dur_l;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        HOLD: begin
          if (cnt == ONE) phase <= IDLE;
          cnt <= cnt - ONE;
        end
        default: cnt <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 hs_cnt <= '0;
    else if (line_ref)       hs_cnt <= wid_l;
    else if (hs_cnt != '0)   hs_cnt <= hs_cnt - ONE;
  end

endmodule

module clamp_strobe_gen_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         line_ref,
  input logic         clamp_ext,
  input logic         clamp_src_ext,
  input logic         clamp_out,
  input logic         hsync_out,
  input logic         trail,
  input logic         clamp_int,
  input logic [W-1:0] wid_l
);

  assert_ext_pass_R1: assert property (@(posedge clk) disable iff (rst)
    clamp_src_ext |-> (clamp_out == clamp_ext));

  assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
    trail |=> !clamp_int);

  assert_hs_start_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync_out) |-> $past(line_ref));

  assert_zero_width_R8: assert property (@(posedge clk) disable iff (rst)
    (line_ref && wid_l == '0) |=> !hsync_out);

  assert_reset_R10: assert property (@(posedge clk)
    rst |=> (!hsync_out && !clamp_int));

endmodule

bind clamp_strobe_gen clamp_strobe_gen_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .line_ref(line_ref), .clamp_ext(clamp_ext),
  .clamp_src_ext(clamp_src_ext), .clamp_out(clamp_out), .hsync_out(hsync_out),
  .trail(trail), .clamp_int(clamp_int), .wid_l(wid_l)
);

// File: tb/clamp_strobe_gen_tb.sv
`timescale 1ns/100ps
module clamp_strobe_gen_tb_top;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst, hs_raw, hs_pol, line_ref, clamp_ext, clamp_src_ext;
  logic [7:0] place_cfg, dur_cfg, hs_width_cfg;
  logic       clamp_out, hsync_out;

  clamp_strobe_gen #(.W(8)) dut_i (
    .clk(clk), .rst(rst), .hs_raw(hs_raw), .hs_pol(hs_pol), .line_ref(line_ref),
    .clamp_ext(clamp_ext), .clamp_src_ext(clamp_src_ext), .place_cfg(place_cfg),
    .dur_cfg(dur_cfg), .hs_width_cfg(hs_width_cfg),
    .clamp_out(clamp_out), .hsync_out(hsync_out)
  );

  int    checks = 0;
  int    fails  = 0;
  string ctag   = "R10";
  string htag   = "R10";

  // reference model state, from the requirement timing
  int n = 0;
  int s_start = -1000000, p_l = 1, d_l = 0, w_l = 0;
  int f_ref = -1000000, w_f = 0;
  bit h1 = 0, h2 = 0, h3 = 0;
  bit exp_int = 0, exp_hs = 0;

  function automatic bit in_win(int now, int first, int len);
    return (now >= first) && (now < first + len);
  endfunction

  function automatic int eff_place(logic [7:0] p);
    return (p == 0) ? 1 : int'(p);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      s_start = -1000000; p_l = 1; d_l = 0; w_l = 0;
      f_ref = -1000000; w_f = 0;
      h1 = 0; h2 = 0; h3 = 0;
    end else begin
      if (line_ref) begin f_ref = n; w_f = w_l; end
      if (h3 && !h2) begin
        s_start = n; p_l = eff_place(place_cfg); d_l = int'(dur_cfg); w_l = int'(hs_width_cfg);
      end
      h3 = h2; h2 = h1; h1 = hs_pol ? hs_raw : !hs_raw;
    end
    exp_int = !rst && in_win(n, s_start + p_l, d_l);
    exp_hs  = !rst && in_win(n, f_ref, w_f);
    n++;
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (clamp_src_ext) chk("R1", clamp_out, clamp_ext);
    else               chk(ctag, clamp_out, exp_int);
    chk(htag, hsync_out, exp_hs);
  endtask

  task automatic line(int len, int hs_len, int ref_pos);
    for (int i = 0; i < len; i++) begin
      hs_raw    = hs_pol ? (i < hs_len) : !(i < hs_len);
      line_ref  = (i == ref_pos);
      clamp_ext = 1'($urandom % 2);
      tick();
    end
  endtask

  task automatic cfg(int p, int d, int w);
    place_cfg = 8'(p); dur_cfg = 8'(d); hs_width_cfg = 8'(w);
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1; hs_raw = 0; hs_pol = 1; line_ref = 0; clamp_ext = 0; clamp_src_ext = 0;
    cfg(0, 0, 0);
    @(negedge clk);
    repeat (3) tick();                       // R10 reset state
    rst = 0;

    ctag = "R9"; htag = "R9";                // width not yet captured
    cfg(3, 4, 5);
    line(30, 5, 1);
    htag = "R7"; ctag = "R3";
    line(30, 5, 10);
    cfg(10, 6, 7);
    line(40, 6, 3);                          // R9: new values used on this line
    line(40, 6, 20);

    ctag = "R4"; cfg(0, 3, 4);
    line(20, 4, 2); line(20, 4, 2);
    ctag = "R5"; cfg(2, 0, 4);
    line(20, 4, 2); line(20, 4, 2);
    ctag = "R6"; cfg(20, 10, 3);
    line(12, 3, 0); line(12, 3, 0); line(12, 3, 0); line(50, 3, 0);
    ctag = "R3"; htag = "R8"; cfg(4, 5, 0);
    line(25, 4, 1); line(25, 4, 1); line(25, 4, 1);

    htag = "R7"; ctag = "R2"; cfg(5, 5, 6);
    hs_pol = 0; hs_raw = 1;
    line(30, 5, 8); line(30, 5, 8); line(30, 5, 8);
    hs_pol = 1; hs_raw = 0;
    line(30, 5, 8);

    ctag = "R3";
    clamp_src_ext = 1; cfg(1, 8, 3);
    line(30, 4, 5); line(30, 4, 5);
    clamp_src_ext = 0;

    for (int k = 0; k < 50; k++) begin
      cfg($urandom % 20, $urandom % 20, $urandom % 20);
      clamp_src_ext = (($urandom % 4) == 0);
      line(20 + ($urandom % 50), 1 + ($urandom % 8), $urandom % 30);
    end
    clamp_src_ext = 0;

    ctag = "R10"; htag = "R10"; cfg(2, 30, 30);
    line(10, 3, 8);
    rst = 1; tick(); tick();
    rst = 0; ctag = "R3"; htag = "R7";
    line(30, 3, 5); line(40, 3, 5);

    summary();
    $finish;
  end

endmodule